// File: doc/BRIEF.md
# Lower memory chip-select decoder

This block generates one active-low chip select for a region of memory that always begins at address zero of a 20-bit memory space. Software sets the top of the region by writing a 16-bit limit register through a simple write port. The register answers at one fixed offset of the control block. Every memory cycle then compares its address against the programmed limit. The bits of the register below bit 6 are treated as ones in this compare, so the region grows in 1K steps.

The three low bits of the same register hold a ready-mode code. This code goes straight to an output, where external wait-state logic can use it. The value in the register after reset has no meaning, so the select stays off until the register has been written at least once. An arming flag records that first write, and only reset clears it.

The select is only driven while the address-valid strobe is high and the cycle is a memory cycle. I/O cycles never assert it.

Top module: `lmsel_top`

## Requirements
- R1: After reset, `sel_n` is 1, `rd_data` is 0038H (bits 5:3 ones, all other bits 0) and `rdy_mode` is 0.
- R2: Until the first write to offset A2H after reset, `sel_n` stays 1 for every address and cycle type.
- R3: A write with `wr_en`=1 and `wr_offset`=A2H stores `wr_data` at the clock edge. The new value shows on `rd_data` from the next cycle. Writes to any other offset leave the register and the arming flag unchanged.
- R4: Once armed, `sel_n` is 0 on a valid memory cycle exactly when `addr[19:4]` is less than or equal to {reg[15:6], 6'b111111}. The region therefore spans 0 to {reg[15:6], 10'h3FF}.
- R5: `sel_n` is 1 whenever `addr_valid` is 0 or `mem_cycle` is 0 (I/O cycle).
- R6: `rd_data` returns the register with bits 5:3 read as ones.
- R7: `rdy_mode` equals register bits 2:0.
- R8: The arming flag stays set across later writes and is cleared only by reset. A later write changes the limit from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_offset | input | 8 | Control-block offset of the write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Register readback, bits 5:3 forced to ones |
| addr | input | 20 | Memory-cycle address |
| addr_valid | input | 1 | Address-valid strobe |
| mem_cycle | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| sel_n | output | 1 | Active-low region select |
| rdy_mode | output | 3 | Ready-mode code for the region |

## Verification
The assertions check on every cycle that:
- the select stays off while unarmed, and on I/O or invalid cycles;
- an address above the programmed top never selects;
- a decoded write lands in the register, and any other write leaves it unchanged;
- the arming flag never drops outside reset.

The exact inclusive boundary at each legal region size can only be shown by the bench's scenarios, by probing one address on each side of it. The same holds for the ready-mode pass-through for each code, for the ignored write to a neighbouring offset, and for the disarm that a second reset causes.

// File: rtl/lmsel_pkg.sv
package lmsel_pkg;
    localparam int unsigned ADDR_W     = 20;
    localparam int unsigned REG_W      = 16;
    localparam int unsigned OFFS_W     = 8;
    localparam int unsigned FORCE_ONES = 6;
    localparam int unsigned MODE_W     = 3;
    localparam int unsigned RB_LO      = 3;   // lowest bit of the read-as-one field
    localparam logic [OFFS_W-1:0] LIMIT_OFFS = 8'hA2;
endpackage

// File: rtl/lmsel_regfile.sv
module lmsel_regfile
    import lmsel_pkg::*;
#(
    parameter int unsigned        P_REG_W  = REG_W,
    parameter int unsigned        P_OFFS_W = OFFS_W,
    parameter logic [P_OFFS_W-1:0] P_OFFS  = LIMIT_OFFS,
    parameter int unsigned        P_RB_LO  = RB_LO,
    parameter int unsigned        P_RB_HI  = FORCE_ONES - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [P_OFFS_W-1:0]  wr_offset,
    input  logic [P_REG_W-1:0]   wr_data,
    output logic [P_REG_W-1:0]   limit_reg,
    output logic                 armed,
    output logic [P_REG_W-1:0]   rd_data
);
    localparam int unsigned RB_N = P_RB_HI - P_RB_LO + 1;
    localparam logic [P_REG_W-1:0] RB_MASK =
        P_REG_W'(((1 << RB_N) - 1) << P_RB_LO);

    typedef struct packed {
        logic [P_REG_W-1:0] limit;
        logic               armed;
    } state_t;

    state_t st_d, st_q;
    logic   hit_w;

    always_comb begin
        hit_w = wr_en && (wr_offset == P_OFFS);
        st_d  = st_q;
        if (hit_w) begin
            st_d.limit = wr_data;
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign limit_reg = st_q.limit;
    assign armed     = st_q.armed;
    assign rd_data   = st_q.limit | RB_MASK;

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_offset == P_OFFS) |=> (limit_reg == $past(wr_data)) && armed);

    assert_other_offs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_offset == P_OFFS) |=> $stable(limit_reg) && $stable(armed));

    assert_arm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);
endmodule

// File: rtl/lmsel_compare.sv
module lmsel_compare
    import lmsel_pkg::*;
#(
    parameter int unsigned P_ADDR_W = ADDR_W,
    parameter int unsigned P_REG_W  = REG_W,
    parameter int unsigned P_ONES   = FORCE_ONES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_ADDR_W-1:0] addr,
    input  logic                addr_valid,
    input  logic                mem_cycle,
    input  logic                armed,
    input  logic [P_REG_W-1:0]  limit_reg,
    output logic                hit
);
    localparam int unsigned PAGE_SH = P_ADDR_W - P_REG_W;

    logic [P_REG_W-1:0]  top_page;
    logic [P_REG_W-1:0]  addr_page;
    logic [P_ADDR_W-1:0] top_addr;

    always_comb begin
        top_page  = {limit_reg[P_REG_W-1:P_ONES], {P_ONES{1'b1}}};
        addr_page = addr[P_ADDR_W-1:PAGE_SH];
        top_addr  = {top_page, {PAGE_SH{1'b1}}};
        hit       = armed && addr_valid && mem_cycle && (addr_page <= top_page);
    end

    assert_above_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr > top_addr) |-> !hit);
endmodule

// File: rtl/lmsel_top.sv
module lmsel_top
    import lmsel_pkg::*;
#(
    parameter int unsigned        P_ADDR_W = ADDR_W,
    parameter int unsigned        P_REG_W  = REG_W,
    parameter int unsigned        P_OFFS_W = OFFS_W,
    parameter int unsigned        P_MODE_W = MODE_W,
    parameter logic [P_OFFS_W-1:0] P_OFFS  = LIMIT_OFFS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [P_OFFS_W-1:0] wr_offset,
    input  logic [P_REG_W-1:0]  wr_data,
    output logic [P_REG_W-1:0]  rd_data,
    input  logic [P_ADDR_W-1:0] addr,
    input  logic                addr_valid,
    input  logic                mem_cycle,
    output logic                sel_n,
    output logic [P_MODE_W-1:0] rdy_mode
);
    logic [P_REG_W-1:0] limit_reg;
    logic               armed;
    logic               hit;

    lmsel_regfile #(
        .P_REG_W (P_REG_W),
        .P_OFFS_W(P_OFFS_W),
        .P_OFFS  (P_OFFS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_offset(wr_offset),
        .wr_data  (wr_data),
        .limit_reg(limit_reg),
        .armed    (armed),
        .rd_data  (rd_data)
    );

    lmsel_compare #(
        .P_ADDR_W(P_ADDR_W),
        .P_REG_W (P_REG_W)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .addr_valid(addr_valid),
        .mem_cycle (mem_cycle),
        .armed     (armed),
        .limit_reg (limit_reg),
        .hit       (hit)
    );

    assign sel_n    = ~hit;
    assign rdy_mode = limit_reg[P_MODE_W-1:0];

    assert_idle_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> sel_n);

    assert_no_io_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid || !mem_cycle) |-> sel_n);
endmodule

// File: tb/sim_lmsel_top.sv
module sim_lmsel_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    // {reg value, address, mem_cycle, addr_valid, expected sel_n}
    typedef struct packed {
        logic [15:0] regv;
        logic [19:0] a;
        logic        mem;
        logic        vld;
        logic        exp_sel;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{16'h0038, 20'h003FF, 1'b1, 1'b1, 1'b0},
        '{16'h0038, 20'h00400, 1'b1, 1'b1, 1'b1},
        '{16'h0078, 20'h007FF, 1'b1, 1'b1, 1'b0},
        '{16'h0078, 20'h00800, 1'b1, 1'b1, 1'b1},
        '{16'h00F8, 20'h00000, 1'b1, 1'b1, 1'b0},
        '{16'h01F9, 20'h01FFF, 1'b1, 1'b1, 1'b0},
        '{16'h03FA, 20'h04000, 1'b1, 1'b1, 1'b1},
        '{16'h07FB, 20'h07FF0, 1'b1, 1'b1, 1'b0},
        '{16'h0FFC, 20'h0FFFF, 1'b0, 1'b1, 1'b1},
        '{16'h1FFD, 20'h10000, 1'b1, 1'b0, 1'b1},
        '{16'h1FFE, 20'h1FFFF, 1'b1, 1'b1, 1'b0},
        '{16'h3FFF, 20'h3FFFF, 1'b1, 1'b1, 1'b0},
        '{16'h3FF8, 20'h40000, 1'b1, 1'b1, 1'b1},
        '{16'h3FF8, 20'hFFFFF, 1'b1, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_offset = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [19:0] addr = '0;
    logic        addr_valid = 1'b0;
    logic        mem_cycle = 1'b0;
    logic        sel_n;
    logic [2:0]  rdy_mode;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lmsel_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_offset(wr_offset),
        .wr_data(wr_data), .rd_data(rd_data), .addr(addr),
        .addr_valid(addr_valid), .mem_cycle(mem_cycle),
        .sel_n(sel_n), .rdy_mode(rdy_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] offs, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_offset = offs; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cycle(input logic [19:0] a, input logic m, input logic v);
        addr = a; mem_cycle = m; addr_valid = v;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 sel_n", 32'(sel_n), 32'd1);
        check("R1 rd_data", 32'(rd_data), 32'h0038);
        check("R1 rdy_mode", 32'(rdy_mode), 32'd0);
        // R2: unarmed, lowest address on a valid memory cycle
        cycle(20'h00000, 1'b1, 1'b1);
        check("R2 unarmed", 32'(sel_n), 32'd1);
        // R3: write to a neighbouring offset is ignored
        reg_write(8'hA0, 16'h3FF8);
        #1;
        check("R3 other offset rd_data", 32'(rd_data), 32'h0038);
        cycle(20'h00000, 1'b1, 1'b1);
        check("R3 other offset no arm", 32'(sel_n), 32'd1);

        // Table walk: R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            reg_write(8'hA2, VECS[i].regv);
            cycle(VECS[i].a, VECS[i].mem, VECS[i].vld);
            check("R4/R5 sel_n", 32'(sel_n), 32'(VECS[i].exp_sel));
            check("R6 rd_data", 32'(rd_data), 32'(VECS[i].regv | 16'h0038));
            check("R7 rdy_mode", 32'(rdy_mode), 32'(VECS[i].regv[2:0]));
        end

        // R8: a later write shrinks the region from the next cycle
        reg_write(8'hA2, 16'h0038);
        cycle(20'h00400, 1'b1, 1'b1);
        check("R8 relimit", 32'(sel_n), 32'd1);
        cycle(20'h003F0, 1'b1, 1'b1);
        check("R8 still armed", 32'(sel_n), 32'd0);
        // R5: an I/O cycle at an in-range address
        cycle(20'h00010, 1'b0, 1'b1);
        check("R5 io cycle", 32'(sel_n), 32'd1);
        // R8: reset disarms
        do_reset();
        cycle(20'h00000, 1'b1, 1'b1);
        check("R8 disarm on reset", 32'(sel_n), 32'd1);
        check("R1 rd_data after reset", 32'(rd_data), 32'h0038);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule